// File: doc/BRIEF.md
# Two-Tone FSK Receive Demodulator with Carrier Qualification

This block takes a stream of signed samples from a band-pass filtered line. The samples carry a phase-continuous two-tone FSK signal at 1200 baud. The block recovers the serial bit stream on `rx_data` and raises `carrier_det` once the signal has been strong enough for several bit times in a row.

A bit is decided by timing the interval between successive sign changes of the samples. A long half-period belongs to the 1200 Hz tone and decodes as 1. A short half-period belongs to the 2200 Hz tone and decodes as 0. Signal strength is measured as the peak-to-peak span of the samples in each bit-time window. The span is compared with a programmable threshold, and a qualifier needs several agreeing windows before carrier detect changes state.

The receiver runs while request-to-send is high. A high duplex input keeps it running regardless of request-to-send. An active-low reset places the block in power-down. The analog front end, the converter and UART deframing sit outside this block.

Top module: `fskd_demod`

## Requirements
- R1: While `carrier_det` is 1, a 1200 Hz tone gives `rx_data` = 1 and a 2200 Hz tone gives `rx_data` = 0. At each sign change of the sample MSB, the interval since the previous sign change is compared with HALF_MID samples (9 at defaults): longer than HALF_MID decodes as 1, HALF_MID or shorter decodes as 0.
- R2: When `rts` = 0 and `duplex` = 0, the receiver is off. On the next clock, `carrier_det` is 0, `rx_data` is 1, and the window, qualifier and tone state are cleared.
- R3: A window is SPB valid samples long (24 at defaults), and windows start at the first valid sample after the receiver turns on. A window counts as "strong" when its peak-to-peak span (maximum minus minimum, unsigned, SMP_W+1 bits) is at least `amp_thr`.
- R4: With the receiver on, `carrier_det` rises only after QUAL_BITS consecutive strong windows (4 at defaults). It is therefore still 0 three bit times after a carrier starts, and it is 1 within six bit times.
- R5: `carrier_det` falls only after QUAL_BITS consecutive weak windows. It is therefore still 1 three bit times after the carrier stops, and it is 0 within six bit times.
- R6: When `rts` rises while a valid carrier is already present, qualification starts afresh. `carrier_det` is still 0 three bit times later and is 1 within six bit times, which is inside the ten-bit-time limit.
- R7: Whenever `carrier_det` is 0, `rx_data` is 1, the UART idle level.
- R8: While `rst_n` is 0, `carrier_det` is 0 and `rx_data` is 1, asynchronously. After release, qualification starts from zero.
- R9: With `duplex` = 1 the receiver stays on and decodes normally even while `rts` = 0.
- R10: A carrier whose span stays below `amp_thr` never raises `carrier_det`, and `rx_data` stays 1.
- R11: A clock with `smp_vld` = 0 changes no decision state. `carrier_det` and `rx_data` hold, whatever `smp_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and power-down |
| smp_vld | input | 1 | Qualifies `smp_data` for one clock |
| smp_data | input | SMP_W | Signed filtered line sample |
| amp_thr | input | SMP_W+1 | Peak-to-peak threshold for a strong window |
| rts | input | 1 | Request-to-send; 1 turns the receiver on |
| duplex | input | 1 | 1 keeps the receiver on regardless of `rts` |
| rx_data | output | 1 | Recovered bit, 1 while no carrier |
| carrier_det | output | 1 | Qualified carrier present |

## Verification
A sign change that settles the decoded bit can land on the very sample that closes a window and flips `carrier_det`. The output gate must then combine the new flag with the new bit. This case is provoked naturally because the tones are phase-continuous and never aligned to the window grid, and a frame runs for many windows while carrier detect rises during the preamble. It is judged by checking `rx_data` mid-bit against the transmitted bit whenever the flag is up, and against 1 whenever it is down. A second collision is a mode change arriving on a window-closing sample. It is exercised by dropping the duplex and request-to-send inputs while the qualifier is saturated, and it is judged by the flag clearing one clock later.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

  typedef enum logic {
    CD_OFF = 1'b0,
    CD_ON  = 1'b1
  } cd_state_e;

  // Midpoint between the two tone half-periods, in samples.
  // Sample rate = spb * baud; half period of tone f = rate / (2 f).
  function automatic int half_mid_samples(input int spb, input int baud,
                                          input int mark, input int space);
    return (spb * baud * (mark + space)) / (4 * mark * space);
  endfunction

endpackage

// File: rtl/fskd_tone_det.sv
module fskd_tone_det #(
  parameter int HALF_MID = 9,
  parameter int CNT_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic smp_vld,
  input  logic smp_sign,
  output logic tone_bit
);

  localparam logic [CNT_W-1:0] MID_C = CNT_W'(HALF_MID);

  logic             sign_q, sign_d;
  logic             have_q, have_d;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             bit_q,  bit_d;

  always_comb begin
    sign_d = sign_q;
    have_d = have_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    if (!en) begin
      sign_d = 1'b0;
      have_d = 1'b0;
      seen_d = 1'b0;
      cnt_d  = '0;
      bit_d  = 1'b1;
    end else if (smp_vld) begin
      if (!have_q) begin
        sign_d = smp_sign;
        have_d = 1'b1;
      end else if (smp_sign != sign_q) begin
        if (seen_q) begin
          bit_d = (cnt_q > MID_C);
        end
        seen_d = 1'b1;
        cnt_d  = {{(CNT_W-1){1'b0}}, 1'b1};
        sign_d = smp_sign;
      end else if (cnt_q != '1) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      have_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= 1'b1;
    end else begin
      sign_q <= sign_d;
      have_q <= have_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
    end
  end

  assign tone_bit = bit_q;

endmodule

// File: rtl/fskd_amp_win.sv
module fskd_amp_win #(
  parameter int SMP_W = 12,
  parameter int SPB   = 24,
  parameter int POS_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp,
  input  logic        [SMP_W:0]   thr,
  output logic                    win_done,
  output logic                    win_above
);

  localparam logic signed [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic signed [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [POS_W-1:0]        LAST  = POS_W'(SPB - 1);

  logic        [POS_W-1:0] pos_q, pos_d;
  logic signed [SMP_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic signed [SMP_W-1:0] hi_n, lo_n;
  logic        [SMP_W:0]   span;
  logic                    at_last;

  // Running extremes including the current sample.
  always_comb begin
    hi_n    = (smp > hi_q) ? smp : hi_q;
    lo_n    = (smp < lo_q) ? smp : lo_q;
    span    = {hi_n[SMP_W-1], hi_n} - {lo_n[SMP_W-1], lo_n};
    at_last = (pos_q == LAST);
  end

  assign win_done  = en & smp_vld & at_last;
  assign win_above = (span >= thr);

  always_comb begin
    pos_d = pos_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (!en) begin
      pos_d = '0;
      hi_d  = S_MIN;
      lo_d  = S_MAX;
    end else if (smp_vld) begin
      if (at_last) begin
        pos_d = '0;
        hi_d  = S_MIN;
        lo_d  = S_MAX;
      end else begin
        pos_d = pos_q + 1'b1;
        hi_d  = hi_n;
        lo_d  = lo_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      hi_q  <= S_MIN;
      lo_q  <= S_MAX;
    end else begin
      pos_q <= pos_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

endmodule

// File: rtl/fskd_cd_qual.sv
module fskd_cd_qual
  import fskd_pkg::*;
#(
  parameter int QUAL  = 4,
  parameter int RUN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic win_done,
  input  logic win_above,
  output logic cd_on
);

  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(QUAL - 1);

  cd_state_e        state_q, state_d;
  logic [RUN_W-1:0] run_q,   run_d;
  logic             disagree;

  assign disagree = (win_above != (state_q == CD_ON));

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (!en) begin
      state_d = CD_OFF;
      run_d   = '0;
    end else if (win_done) begin
      if (disagree) begin
        if (run_q == LAST_RUN) begin
          state_d = (state_q == CD_ON) ? CD_OFF : CD_ON;
          run_d   = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CD_OFF;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign cd_on = (state_q == CD_ON);

endmodule

// File: rtl/fskd_demod.sv
module fskd_demod
  import fskd_pkg::*;
#(
  parameter int SMP_W     = 12,
  parameter int SPB       = 24,
  parameter int BAUD_HZ   = 1200,
  parameter int MARK_HZ   = 1200,
  parameter int SPACE_HZ  = 2200,
  parameter int QUAL_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic        [SMP_W:0]   amp_thr,
  input  logic                    rts,
  input  logic                    duplex,
  output logic                    rx_data,
  output logic                    carrier_det
);

  localparam int HALF_MID = half_mid_samples(SPB, BAUD_HZ, MARK_HZ, SPACE_HZ);
  localparam int POS_W    = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int CNT_W    = $clog2(SPB + 1) + 1;
  localparam int RUN_W    = $clog2(QUAL_BITS + 1);

  logic rx_en;
  logic tone_bit;
  logic win_done;
  logic win_above;
  logic cd_on;

  assign rx_en = rts | duplex;

  fskd_tone_det #(
    .HALF_MID (HALF_MID),
    .CNT_W    (CNT_W)
  ) tone_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .smp_vld  (smp_vld),
    .smp_sign (smp_data[SMP_W-1]),
    .tone_bit (tone_bit)
  );

  fskd_amp_win #(
    .SMP_W (SMP_W),
    .SPB   (SPB),
    .POS_W (POS_W)
  ) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .smp_vld   (smp_vld),
    .smp       (smp_data),
    .thr       (amp_thr),
    .win_done  (win_done),
    .win_above (win_above)
  );

  fskd_cd_qual #(
    .QUAL  (QUAL_BITS),
    .RUN_W (RUN_W)
  ) qual_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .win_done  (win_done),
    .win_above (win_above),
    .cd_on     (cd_on)
  );

  assign carrier_det = cd_on;
  assign rx_data     = cd_on ? tone_bit : 1'b1;

endmodule

// File: rtl/fskd_demod_chk.sv
module fskd_demod_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic rts,
  input logic duplex,
  input logic rx_data,
  input logic carrier_det
);

  // R8: power-down forces the idle outputs
  assert_pd_idle_R8: assert property (@(posedge clk)
    !rst_n |-> (!carrier_det && rx_data));

  // R7: no carrier means idle mark on the data line
  assert_gap_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_det |-> rx_data);

  // R2: receiver off clears the flag on the next clock
  assert_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rts || duplex) |=> !carrier_det);

  // R4: the flag rises only on a sample clock
  assert_rise_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_det) |-> $past(smp_vld));

  // R6: the flag rises only while the receiver was on
  assert_rise_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_det) |-> $past(rts || duplex));

  // R5: the flag falls on a sample clock or because the receiver turned off
  assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_det) |-> ($past(smp_vld) || !$past(rts || duplex)));

  // R11: clocks without a valid sample leave the outputs alone
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && (rts || duplex)) |=> ($stable(carrier_det) && $stable(rx_data)));

endmodule

bind fskd_demod fskd_demod_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_vld     (smp_vld),
  .rts         (rts),
  .duplex      (duplex),
  .rx_data     (rx_data),
  .carrier_det (carrier_det)
);

// File: tb/fskd_demod_tb_top.sv
module fskd_demod_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  SMP_W      = 12;
  localparam int  SPB        = 24;
  localparam int  SMP_DIV    = 4;
  localparam int  THR        = 400;
  localparam int  WD_CYCLES  = 150000;
  localparam real FS         = 28800.0;
  localparam real TWO_PI     = 6.283185307179586;
  localparam int  N_VEC      = 7;
  // amplitude, rts, duplex, byte, expected carrier
  localparam int  VEC [N_VEC][5] = '{
    '{600, 1, 0, 'hFF, 1},
    '{600, 1, 0, 'h00, 1},
    '{600, 0, 1, 'hA5, 1},
    '{600, 1, 1, 'h3C, 1},
    '{150, 1, 0, 'hFF, 0},
    '{600, 0, 0, 'h5A, 0},
    '{900, 1, 0, 'hC3, 1}
  };

  logic                    clk;
  logic                    rst_n;
  logic                    smp_vld;
  logic signed [SMP_W-1:0] smp_data;
  logic        [SMP_W:0]   amp_thr;
  logic                    rts;
  logic                    duplex;
  logic                    rx_data;
  logic                    carrier_det;

  int  n_checks;
  int  n_err;
  real phase;

  fskd_demod dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .amp_thr     (amp_thr),
    .rts         (rts),
    .duplex      (duplex),
    .rx_data     (rx_data),
    .carrier_det (carrier_det)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put_sample(input logic b, input int amp);
    real f;
    f = b ? 1200.0 : 2200.0;
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_data = SMP_W'($rtoi(amp * $sin(phase)));
    phase    = phase + TWO_PI * f / FS;
    if (phase > TWO_PI) phase = phase - TWO_PI;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (SMP_DIV - 2) @(negedge clk);
  endtask

  // One bit time; optional mid-bit check of both outputs.
  task automatic send_bit(input logic b, input int amp, input logic chk,
                          input logic exp_cd, input string req);
    for (int s = 0; s < SPB; s++) begin
      put_sample(b, amp);
      if (chk && s == SPB/2) begin
        check(req, "carrier_det mid-bit", carrier_det, exp_cd);
        check(req, "rx_data mid-bit", rx_data, exp_cd ? b : 1'b1);
      end
    end
  endtask

  task automatic send_bits(input int n, input logic b, input int amp);
    for (int i = 0; i < n; i++) send_bit(b, amp, 1'b0, 1'b0, "");
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [10:0] frame;
    logic        prev;
    string       tag;
    n_checks = 0;
    n_err    = 0;
    phase    = 0.3;
    rst_n    = 1'b0;
    smp_vld  = 1'b0;
    smp_data = '0;
    amp_thr  = (SMP_W+1)'(THR);
    rts      = 1'b0;
    duplex   = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "reset carrier_det", carrier_det, 1'b0);
    check("R8", "reset rx_data", rx_data, 1'b1);
    rst_n = 1'b1;

    // Vector walk: mode, amplitude and byte pattern per entry
    for (int v = 0; v < N_VEC; v++) begin
      rts = 1'b0; duplex = 1'b0;
      send_bits(2, 1'b1, 0);
      check("R2", "cleared carrier_det", carrier_det, 1'b0);
      check("R2", "cleared rx_data", rx_data, 1'b1);
      rts    = VEC[v][1][0];
      duplex = VEC[v][2][0];
      if (VEC[v][4] == 0) tag = (VEC[v][1] == 0 && VEC[v][2] == 0) ? "R2" : "R10";
      else tag = (VEC[v][1] == 0) ? "R9" : "R1";
      send_bits(8, 1'b1, VEC[v][0]);
      check((VEC[v][4] != 0) ? "R4" : tag, "after preamble carrier_det",
            carrier_det, VEC[v][4][0]);
      // start 0, data LSB first, odd parity, stop 1
      frame = {1'b1, ~(^VEC[v][3][7:0]), VEC[v][3][7:0], 1'b0};
      prev  = 1'b1;
      for (int r = 0; r < 2; r++) begin
        for (int i = 0; i < 11; i++) begin
          send_bit(frame[i], VEC[v][0], (frame[i] == prev) || (VEC[v][4] == 0),
                   VEC[v][4][0], tag);
          prev = frame[i];
        end
      end
      send_bits(8, 1'b1, 0);
      check("R5", "after carrier loss carrier_det", carrier_det, 1'b0);
      check("R7", "after carrier loss rx_data", rx_data, 1'b1);
    end

    // R4: assert qualification window
    rts = 1'b0; duplex = 1'b0;
    send_bits(2, 1'b1, 0);
    rts = 1'b1;
    send_bits(3, 1'b1, 600);
    check("R4", "3 bits after carrier start", carrier_det, 1'b0);
    send_bits(3, 1'b1, 600);
    check("R4", "6 bits after carrier start", carrier_det, 1'b1);

    // R5: deassert qualification window
    send_bits(3, 1'b1, 0);
    check("R5", "3 bits after carrier stop", carrier_det, 1'b1);
    send_bits(3, 1'b1, 0);
    check("R5", "6 bits after carrier stop", carrier_det, 1'b0);
    check("R7", "idle after stop", rx_data, 1'b1);

    // R6: turn-around with carrier already present
    rts = 1'b0;
    send_bits(4, 1'b1, 600);
    check("R2", "transmit mode carrier_det", carrier_det, 1'b0);
    check("R2", "transmit mode rx_data", rx_data, 1'b1);
    rts = 1'b1;
    send_bits(3, 1'b1, 600);
    check("R6", "3 bits after rts rise", carrier_det, 1'b0);
    send_bits(3, 1'b1, 600);
    check("R6", "6 bits after rts rise", carrier_det, 1'b1);

    // R9: duplex keeps the receiver on with rts low
    duplex = 1'b1; rts = 1'b0;
    send_bits(2, 1'b1, 600);
    check("R9", "duplex keeps carrier_det", carrier_det, 1'b1);
    duplex = 1'b0;
    put_sample(1'b1, 600);
    check("R2", "both modes off carrier_det", carrier_det, 1'b0);

    // R11: invalid clocks are ignored
    rts = 1'b1;
    send_bits(6, 1'b0, 600);
    check("R1", "space decodes 0", rx_data, 1'b0);
    check("R1", "space carrier_det", carrier_det, 1'b1);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      smp_data = (i % 2 == 0) ? 12'sh700 : -12'sh700;
    end
    check("R11", "pause carrier_det", carrier_det, 1'b1);
    check("R11", "pause rx_data", rx_data, 1'b0);

    // R3: threshold boundary around the window span
    amp_thr = 13'd1300;
    send_bits(6, 1'b0, 600);
    check("R3", "span below raised threshold", carrier_det, 1'b0);
    amp_thr = 13'd1100;
    send_bits(6, 1'b0, 600);
    check("R3", "span above lowered threshold", carrier_det, 1'b1);
    amp_thr = (SMP_W+1)'(THR);

    // R8: reset in the middle of reception
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", "async reset carrier_det", carrier_det, 1'b0);
    check("R8", "async reset rx_data", rx_data, 1'b1);
    put_sample(1'b0, 600);
    put_sample(1'b0, 600);
    check("R8", "held reset carrier_det", carrier_det, 1'b0);
    rst_n = 1'b1;
    send_bits(3, 1'b0, 600);
    check("R8", "requalify after reset", carrier_det, 1'b0);
    check("R7", "idle while requalifying", rx_data, 1'b1);

    summary();
    $finish;
  end

endmodule